// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Timing

This unit forms the effective address for one operand of an 8-bit processor with a 16-bit address space. A pulse on `start`, together with a mode code, an access type, the two index registers and the current program counter, sets it running. It then fetches the operand bytes, and any pointer bytes in page zero, through a synchronous read port. It steps the program counter past every operand byte it consumes. When the address is known it raises `done` for one cycle. Alongside `done` it presents the final address, the updated program counter, the number of penalty cycles the addressing cost, and any dummy read it issued, with that read's address.

Reads and stores treat indexing differently. A read pays one penalty cycle and one dummy read only when adding the index moves the address into another page. A write or read-modify-write always spends one dummy read at the address formed before the page carry is applied, and pays no penalty cycle. Relative branches report the target and cost one or two extra cycles when taken. The operation itself and interrupts belong to the surrounding core.

The controller is a single state machine with these states: `S_IDLE`, `S_OPND` (fetch first operand byte), `S_OPND2` (fetch second operand byte), `S_ZPCAP` (form a page-zero address), `S_PTR_LO` and `S_PTR_HI` (fetch pointer bytes), `S_INDEX` (add index, judge page cross), `S_DUMMY` (issue dummy read), `S_BRANCH` (resolve displacement) and `S_DONE`. The transitions are as follows:
- `S_IDLE` goes to `S_DONE` for immediate mode and to `S_OPND` for every other mode.
- `S_OPND` goes to `S_OPND2` for absolute modes, to `S_ZPCAP` for page-zero modes, to `S_PTR_LO` for indirect modes and to `S_BRANCH` for branches.
- `S_OPND2` goes to `S_INDEX`.
- `S_PTR_LO` goes to `S_PTR_HI`, and `S_PTR_HI` goes to `S_INDEX`.
- `S_INDEX` goes to `S_DUMMY` or `S_DONE`.
- `S_ZPCAP`, `S_DUMMY` and `S_BRANCH` go to `S_DONE`.
- `S_DONE` goes to `S_IDLE`.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset `done`, `mem_rd` and `dummy_valid` are low and `extra_cycles` is 0.
- R2: The mode codes are 0 immediate, 1 page zero, 2 page zero + X, 3 page zero + Y, 4 absolute, 5 absolute + X, 6 absolute + Y, 7 indexed indirect (X), 8 indirect indexed (Y) and 9 relative; codes 10 to 15 act as immediate. In immediate mode the address is the starting program counter, the program counter advances by one and no memory read is made.
- R3: Page-zero modes fetch one operand byte, and the address is 0x00 in the high byte with (operand + index) mod 256 in the low byte. The program counter advances by one.
- R4: Absolute modes fetch the low byte at the program counter and then the high byte at the next address. The program counter advances by two.
- R5: For reads (`acc_wr`=0) in modes 5, 6 and 8, when the indexed address differs from the base in bits 15:8, the unit makes one dummy read at the final address with bit 8 inverted and reports `extra_cycles`=1. Otherwise it makes no dummy read and reports 0.
- R6: For writes or read-modify-writes (`acc_wr`=1) in modes 5, 6 and 8, the unit always makes exactly one dummy read at {base bits 15:8, final bits 7:0} and reports `extra_cycles`=0.
- R7: Indexed indirect forms the pointer p = (operand + X) mod 256. It reads the address low byte at 0x00p and the high byte at 0x00((p+1) mod 256).
- R8: Indirect indexed reads the base from page-zero locations z and (z+1) mod 256. It then adds Y, and the sum wraps modulo 65536.
- R9: A relative branch fetches a signed displacement. When not taken, the address and program counter equal the address after the displacement byte and `extra_cycles` is 0. When taken, both equal that address plus the displacement, and `extra_cycles` is 1, or 2 if bits 15:8 change.
- R10: `done` lasts exactly one cycle. `dummy_valid` is high only together with `mem_rd`. The address, program counter and extra-cycle outputs hold their values after `done` until the next start.
- R11: The memory returns `mem_rdata` in the cycle after the one in which `mem_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one address computation (honoured in idle) |
| mode | input | 4 | Addressing mode code |
| acc_wr | input | 1 | 1 for write or read-modify-write, 0 for read |
| br_taken | input | 1 | Branch condition for relative mode |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| pc_in | input | 16 | Program counter at the first operand byte |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| pc_out | output | 16 | Updated program counter |
| ea | output | 16 | Effective address |
| done | output | 1 | One-cycle completion strobe |
| extra_cycles | output | 2 | Penalty cycles of this addressing |
| dummy_valid | output | 1 | Current read is a dummy read |
| dummy_addr | output | 16 | Address of the dummy read |

## Verification
The bench targets the corners where the carries wrap. It checks page-zero indexing that overflows past 0xFF, indirect pointers whose second byte sits at 0x00, and an indirect-indexed sum that wraps past 0xFFFF. A design that let the carry through would point into page one or beyond. Indexed reads with and without a page crossing are set against stores on the same bases: a design that confused the two would drop the store's dummy read, charge it a penalty, or use the wrong dummy address. Branches go forward and backward, with and without a page change, so an unsigned displacement or a missing second penalty cycle shows up at once.

// File: rtl/eau_pkg.sv
package eau_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM  = 4'd0,
        AM_ZP   = 4'd1,
        AM_ZPX  = 4'd2,
        AM_ZPY  = 4'd3,
        AM_ABS  = 4'd4,
        AM_ABSX = 4'd5,
        AM_ABSY = 4'd6,
        AM_INDX = 4'd7,
        AM_INDY = 4'd8,
        AM_REL  = 4'd9
    } amode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPND,
        S_OPND2,
        S_ZPCAP,
        S_PTR_LO,
        S_PTR_HI,
        S_INDEX,
        S_DUMMY,
        S_BRANCH,
        S_DONE
    } ast_e;

endpackage

// File: rtl/eau_index_add.sv
module eau_index_add #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] sum,
    output logic          crossed,
    output logic [AW-1:0] unfixed,
    output logic [AW-1:0] flipped
);
    localparam logic [AW-1:0] PAGE_BIT = AW'(1) << DW;

    always_comb begin
        sum     = base + {{DW{1'b0}}, idx};
        crossed = (sum[AW-1:DW] != base[AW-1:DW]);
        unfixed = {base[AW-1:DW], sum[DW-1:0]};
        flipped = sum ^ PAGE_BIT;
    end
endmodule

// File: rtl/eau_branch_calc.sv
module eau_branch_calc #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic [AW-1:0] pc_next,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] target,
    output logic          page_chg
);
    always_comb begin
        target   = pc_next + {{DW{disp[DW-1]}}, disp};
        page_chg = (target[AW-1:DW] != pc_next[AW-1:DW]);
    end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eau_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int AW = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic              acc_wr,
    input  logic              br_taken,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [AW-1:0]     pc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     pc_out,
    output logic [AW-1:0]     ea,
    output logic              done,
    output logic [1:0]        extra_cycles,
    output logic              dummy_valid,
    output logic [AW-1:0]     dummy_addr
);
    localparam logic [DATA_W-1:0] ZERO_B = '0;

    ast_e              st_q, st_n;
    amode_e            mode_q, mode_n;
    logic              wr_q, wr_n, tk_q, tk_n;
    logic [DATA_W-1:0] x_q, x_n, y_q, y_n;
    logic [DATA_W-1:0] lo_q, lo_n, ptr_q, ptr_n;
    logic [AW-1:0]     pc_q, pc_n, ea_q, ea_n, dum_q, dum_n;
    logic [1:0]        xtra_q, xtra_n;

    logic [DATA_W-1:0] zp_idx, ix_idx, ptr_now;
    logic              is_indexed, start_imm;
    logic [AW-1:0]     ix_sum, ix_unfixed, ix_flipped, br_target;
    logic              ix_cross, br_page;

    always_comb begin
        unique case (mode_q)
            AM_ZPX:  zp_idx = x_q;
            AM_ZPY:  zp_idx = y_q;
            default: zp_idx = ZERO_B;
        endcase
        unique case (mode_q)
            AM_ABSX:         ix_idx = x_q;
            AM_ABSY, AM_INDY: ix_idx = y_q;
            default:         ix_idx = ZERO_B;
        endcase
        is_indexed = (mode_q == AM_ABSX) || (mode_q == AM_ABSY) || (mode_q == AM_INDY);
        ptr_now    = (mode_q == AM_INDX) ? mem_rdata + x_q : mem_rdata;
        start_imm  = (mode == MODE_W'(AM_IMM)) || (mode > MODE_W'(AM_REL));
    end

    eau_index_add #(.DW(DATA_W)) u_idx (
        .base    ({mem_rdata, lo_q}),
        .idx     (ix_idx),
        .sum     (ix_sum),
        .crossed (ix_cross),
        .unfixed (ix_unfixed),
        .flipped (ix_flipped)
    );

    eau_branch_calc #(.DW(DATA_W)) u_br (
        .pc_next  (pc_q),
        .disp     (mem_rdata),
        .target   (br_target),
        .page_chg (br_page)
    );

    // next-state and datapath
    always_comb begin
        st_n   = st_q;
        mode_n = mode_q;
        wr_n   = wr_q;
        tk_n   = tk_q;
        x_n    = x_q;
        y_n    = y_q;
        lo_n   = lo_q;
        ptr_n  = ptr_q;
        pc_n   = pc_q;
        ea_n   = ea_q;
        dum_n  = dum_q;
        xtra_n = xtra_q;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    wr_n   = acc_wr;
                    tk_n   = br_taken;
                    x_n    = idx_x;
                    y_n    = idx_y;
                    xtra_n = 2'd0;
                    if (start_imm) begin
                        mode_n = AM_IMM;
                        ea_n   = pc_in;
                        pc_n   = pc_in + AW'(1);
                        st_n   = S_DONE;
                    end else begin
                        mode_n = amode_e'(mode);
                        pc_n   = pc_in;
                        st_n   = S_OPND;
                    end
                end
            end
            S_OPND: begin
                pc_n = pc_q + AW'(1);
                unique case (mode_q)
                    AM_ABS, AM_ABSX, AM_ABSY: st_n = S_OPND2;
                    AM_ZP, AM_ZPX, AM_ZPY:    st_n = S_ZPCAP;
                    AM_INDX, AM_INDY:         st_n = S_PTR_LO;
                    AM_REL:                   st_n = S_BRANCH;
                    default:                  st_n = S_DONE;
                endcase
            end
            S_ZPCAP: begin
                ea_n = {ZERO_B, mem_rdata + zp_idx};
                st_n = S_DONE;
            end
            S_OPND2: begin
                lo_n = mem_rdata;
                pc_n = pc_q + AW'(1);
                st_n = S_INDEX;
            end
            S_PTR_LO: begin
                ptr_n = ptr_now + DATA_W'(1);
                st_n  = S_PTR_HI;
            end
            S_PTR_HI: begin
                lo_n = mem_rdata;
                st_n = S_INDEX;
            end
            S_INDEX: begin
                ea_n = ix_sum;
                st_n = S_DONE;
                if (is_indexed) begin
                    if (wr_q) begin
                        dum_n = ix_unfixed;
                        st_n  = S_DUMMY;
                    end else if (ix_cross) begin
                        dum_n  = ix_flipped;
                        xtra_n = 2'd1;
                        st_n   = S_DUMMY;
                    end
                end
            end
            S_DUMMY: st_n = S_DONE;
            S_BRANCH: begin
                if (tk_q) begin
                    ea_n   = br_target;
                    pc_n   = br_target;
                    xtra_n = br_page ? 2'd2 : 2'd1;
                end else begin
                    ea_n = pc_q;
                end
                st_n = S_DONE;
            end
            S_DONE: st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            mode_q <= AM_IMM;
            wr_q   <= 1'b0;
            tk_q   <= 1'b0;
            x_q    <= '0;
            y_q    <= '0;
            lo_q   <= '0;
            ptr_q  <= '0;
            pc_q   <= '0;
            ea_q   <= '0;
            dum_q  <= '0;
            xtra_q <= 2'd0;
        end else begin
            st_q   <= st_n;
            mode_q <= mode_n;
            wr_q   <= wr_n;
            tk_q   <= tk_n;
            x_q    <= x_n;
            y_q    <= y_n;
            lo_q   <= lo_n;
            ptr_q  <= ptr_n;
            pc_q   <= pc_n;
            ea_q   <= ea_n;
            dum_q  <= dum_n;
            xtra_q <= xtra_n;
        end
    end

    // outputs
    always_comb begin
        mem_rd      = 1'b0;
        mem_addr    = pc_q;
        dummy_valid = 1'b0;
        unique case (st_q)
            S_OPND, S_OPND2: mem_rd = 1'b1;
            S_PTR_LO: begin
                mem_rd   = 1'b1;
                mem_addr = {ZERO_B, ptr_now};
            end
            S_PTR_HI: begin
                mem_rd   = 1'b1;
                mem_addr = {ZERO_B, ptr_q};
            end
            S_DUMMY: begin
                mem_rd      = 1'b1;
                mem_addr    = dum_q;
                dummy_valid = 1'b1;
            end
            default: ;
        endcase
        done         = (st_q == S_DONE);
        pc_out       = pc_q;
        ea           = ea_q;
        extra_cycles = xtra_q;
        dummy_addr   = dum_q;
    end
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk
    import eau_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [3:0]  mode,
    input logic        acc_wr,
    input logic        done,
    input logic        mem_rd,
    input logic        dummy_valid,
    input logic [15:0] ea,
    input logic [1:0]  extra_cycles
);
    logic       busy_q;
    logic [3:0] cm_q;
    logic       cw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cm_q   <= 4'd0;
            cw_q   <= 1'b0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            cm_q   <= mode;
            cw_q   <= acc_wr;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    dummy_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_valid |-> mem_rd);

    // R3
    zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cm_q == 4'd1 || cm_q == 4'd2 || cm_q == 4'd3)) |-> (ea[15:8] == 8'h00));

    // R6
    store_no_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cw_q && (cm_q == 4'd5 || cm_q == 4'd6 || cm_q == 4'd8)) |-> (extra_cycles == 2'd0));

    // R5
    read_penalty_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cm_q != 4'd9) |-> (extra_cycles <= 2'd1));

    // R2
    imm_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cm_q == 4'd0 || cm_q > 4'd9)) |-> !$past(mem_rd));
endmodule

bind eff_addr_gen eff_addr_gen_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode         (mode),
    .acc_wr       (acc_wr),
    .done         (done),
    .mem_rd       (mem_rd),
    .dummy_valid  (dummy_valid),
    .ea           (ea),
    .extra_cycles (extra_cycles)
);

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        acc_wr = 1'b0;
    logic        br_taken = 1'b0;
    logic [7:0]  idx_x = 8'd0;
    logic [7:0]  idx_y = 8'd0;
    logic [15:0] pc_in = 16'd0;
    logic [7:0]  mem_rdata = 8'd0;
    logic        mem_rd;
    logic [15:0] mem_addr, pc_out, ea, dummy_addr;
    logic        done, dummy_valid;
    logic [1:0]  extra_cycles;

    int checks = 0;
    int fails = 0;
    int dcnt = 0;
    int rcnt = 0;
    logic [15:0] dlast = 16'd0;
    int cyc = 0;

    logic [7:0] mem_aa [int];

    always #10 clk = ~clk;

    eff_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .acc_wr(acc_wr),
        .br_taken(br_taken), .idx_x(idx_x), .idx_y(idx_y), .pc_in(pc_in),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .pc_out(pc_out), .ea(ea), .done(done), .extra_cycles(extra_cycles),
        .dummy_valid(dummy_valid), .dummy_addr(dummy_addr)
    );

    // R11: data returned one cycle after the request
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= mem_aa.exists(int'(mem_addr)) ? mem_aa[int'(mem_addr)] : 8'h00;
    end

    always @(negedge clk) begin
        if (dummy_valid) begin
            dcnt  = dcnt + 1;
            dlast = dummy_addr;
        end
        if (mem_rd) rcnt = rcnt + 1;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] m, input logic w, input logic tk, input logic [15:0] pc0);
        int n;
        @(negedge clk);
        mode = m; acc_wr = w; br_taken = tk; pc_in = pc0; start = 1'b1;
        dcnt = 0; rcnt = 0;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk("R10", "done timeout", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        chk("R1", "done", done, 0);
        chk("R1", "mem_rd", mem_rd, 0);
        chk("R1", "dummy_valid", dummy_valid, 0);
        chk("R1", "extra", extra_cycles, 0);
    endtask

    task automatic t_imm();
        run(4'd0, 1'b0, 1'b0, 16'h1234);
        chk("R2", "imm ea", ea, 16'h1234);
        chk("R2", "imm pc", pc_out, 16'h1235);
        chk("R2", "imm reads", rcnt, 0);
        run(4'd13, 1'b0, 1'b0, 16'h2222);
        chk("R2", "bad code ea", ea, 16'h2222);
        chk("R2", "bad code reads", rcnt, 0);
    endtask

    task automatic t_zp();
        mem_aa.delete();
        mem_aa[32'h2000] = 8'h80;
        idx_x = 8'h90; idx_y = 8'h05;
        run(4'd1, 1'b0, 1'b0, 16'h2000);
        chk("R3", "zp ea", ea, 16'h0080);
        chk("R3", "zp pc", pc_out, 16'h2001);
        run(4'd2, 1'b0, 1'b0, 16'h2000);
        chk("R3", "zpx wrap ea", ea, 16'h0010);
        run(4'd3, 1'b0, 1'b0, 16'h2000);
        chk("R3", "zpy ea", ea, 16'h0085);
    endtask

    task automatic t_abs();
        mem_aa.delete();
        mem_aa[32'h3000] = 8'h34; mem_aa[32'h3001] = 8'h12;
        mem_aa[32'h3100] = 8'hF0; mem_aa[32'h3101] = 8'h12;
        run(4'd4, 1'b0, 1'b0, 16'h3000);
        chk("R4", "abs ea", ea, 16'h1234);
        chk("R4", "abs pc", pc_out, 16'h3002);
        chk("R4", "abs dummies", dcnt, 0);
        idx_x = 8'h10; idx_y = 8'h20;
        run(4'd5, 1'b0, 1'b0, 16'h3000);
        chk("R5", "absx nocross ea", ea, 16'h1244);
        chk("R5", "absx nocross extra", extra_cycles, 0);
        chk("R5", "absx nocross dummies", dcnt, 0);
        run(4'd6, 1'b0, 1'b0, 16'h3100);
        chk("R5", "absy cross ea", ea, 16'h1310);
        chk("R5", "absy cross extra", extra_cycles, 1);
        chk("R5", "absy cross dummies", dcnt, 1);
        chk("R5", "absy cross dummy addr", dlast, 16'h1210);
        // stores on the same bases
        run(4'd5, 1'b1, 1'b0, 16'h3000);
        chk("R6", "st nocross dummies", dcnt, 1);
        chk("R6", "st nocross dummy addr", dlast, 16'h1244);
        chk("R6", "st nocross extra", extra_cycles, 0);
        run(4'd6, 1'b1, 1'b0, 16'h3100);
        chk("R6", "st cross ea", ea, 16'h1310);
        chk("R6", "st cross dummy addr", dlast, 16'h1210);
        chk("R6", "st cross extra", extra_cycles, 0);
        chk("R6", "st cross dummies", dcnt, 1);
    endtask

    task automatic t_ind();
        mem_aa.delete();
        mem_aa[32'h5000] = 8'hFE;
        mem_aa[32'h00FF] = 8'h78; mem_aa[32'h0000] = 8'h56;
        idx_x = 8'h01;
        run(4'd7, 1'b0, 1'b0, 16'h5000);
        chk("R7", "indx wrap ea", ea, 16'h5678);
        chk("R7", "indx pc", pc_out, 16'h5001);
        mem_aa.delete();
        mem_aa[32'h5000] = 8'hFF;
        mem_aa[32'h00FF] = 8'hF0; mem_aa[32'h0000] = 8'hFF;
        idx_y = 8'h20;
        run(4'd8, 1'b0, 1'b0, 16'h5000);
        chk("R8", "indy wrap ea", ea, 16'h0010);
        chk("R5", "indy cross extra", extra_cycles, 1);
        chk("R5", "indy cross dummy addr", dlast, 16'h0110);
    endtask

    task automatic t_branch();
        logic [15:0] hold;
        mem_aa.delete();
        mem_aa[32'h4000] = 8'h10;
        mem_aa[32'h4100] = 8'hF0;
        mem_aa[32'h40F0] = 8'h20;
        run(4'd9, 1'b0, 1'b0, 16'h4000);
        chk("R9", "not taken ea", ea, 16'h4001);
        chk("R9", "not taken extra", extra_cycles, 0);
        run(4'd9, 1'b0, 1'b1, 16'h4000);
        chk("R9", "taken fwd pc", pc_out, 16'h4011);
        chk("R9", "taken fwd extra", extra_cycles, 1);
        run(4'd9, 1'b0, 1'b1, 16'h4100);
        chk("R9", "taken back pc", pc_out, 16'h40F1);
        chk("R9", "taken back extra", extra_cycles, 2);
        run(4'd9, 1'b0, 1'b1, 16'h40F0);
        chk("R9", "taken cross ea", ea, 16'h4111);
        chk("R9", "taken cross extra", extra_cycles, 2);
        hold = ea;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "done single", done, 0);
        chk("R10", "ea held", ea, hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm();
        t_zp();
        t_abs();
        t_ind();
        t_branch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule